// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block is one group of a programmable parallel interface running strobed transfers. The group owns one data port, eight bits wide by default, whose direction is fixed by a configuration input. In either direction the data passes through a register, so nothing reaches the other side without a handshake. In input mode, a device drives the pins and pulses an active-low strobe. The port captures the pins, raises an input-buffer-full flag and tells the host. In output mode, a host write loads the output register and pulls an active-low output-buffer-full line. The device pulses an active-low acknowledge once it has taken the byte.

The host sees two locations. Address 0 is the data port. Address 1 is a control/status location, and it is laid out like the shared control port of the full interface. Each group owns a fixed three-bit slice of that location: bits 2..0 for group B and bits 5..3 for group A. The slice holds the interrupt request, the interrupt enable and the buffer-full flag. The top two bits are independent data lines that are not used for handshaking.

A completed transfer leaves a pending flag set. The interrupt request is that flag gated by the enable bit. The next host read or write of the data port clears the request.

Top module: `hs_strobed_port`

## Requirements
- R1: After reset, ibf_o is 0, obf_no is 1, irq_o is 0, the interrupt enable is 0, both data registers hold 0, and aux_o is 0.
- R2: In input mode (cfg_dir_in_i=1), a falling edge of stb_ack_ni, seen at a clock edge, loads pad_data_i into the input register and sets ibf_o on that same edge. Changes on the pins while the strobe stays high or stays low do not alter the register.
- R3: A host read of address 0 in input mode returns the input register, and ibf_o is 0 after that clock edge. If a strobe falling edge arrives in the same cycle, the strobe wins: ibf_o stays 1 and the new byte is loaded.
- R4: In output mode (cfg_dir_in_i=0), a host write of address 0 loads host_wdata_i into the output register, which drives pad_data_o with pad_data_oe_o=1. obf_no goes low on that edge.
- R5: In output mode, a falling edge of stb_ack_ni while obf_no is low drives obf_no high and completes the transfer. An acknowledge while obf_no is already high completes nothing. A host data write in the same cycle as the acknowledge wins: obf_no stays low and the new byte is driven.
- R6: A completed transfer (R2 strobe or R5 acknowledge) sets a pending flag. irq_o = pending AND enable. Any host read or write of address 0 clears the pending flag unless a transfer completes in the same cycle.
- R7: A host write of address 1 sets the enable from bit BASE+1 of host_wdata_i, where BASE is 3 for group A (GRP_A=1) and 0 for group B. Setting the enable after a completion raises irq_o on that edge. Clearing it drops irq_o.
- R8: A read of address 1 returns irq_o at bit BASE, the enable at bit BASE+1, and the buffer-full state (ibf_o in input mode, NOT obf_no in output mode) at bit BASE+2. It returns aux_i at bits 7:6 and 0 in every other bit.
- R9: A host write of address 1 loads host_wdata_i bits 7:6 into aux_o.
- R10: In input mode, a host write of address 0 changes neither the input register nor ibf_o, and pad_data_oe_o is 0.
- R11: A strobe held low counts once: after a host read clears ibf_o, ibf_o stays 0 for as long as the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_dir_in_i | input | 1 | 1 = input mode, 0 = output mode |
| host_addr_i | input | 1 | 0 = data port, 1 = control/status |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data, combinational |
| pad_data_i | input | DW | Data pins from the device (input mode) |
| pad_data_o | output | DW | Data pins to the device (output mode) |
| pad_data_oe_o | output | 1 | Output enable for the data pins |
| stb_ack_ni | input | 1 | Strobe (input mode) or acknowledge (output mode), active low |
| ibf_o | output | 1 | Input buffer full, active high |
| obf_no | output | 1 | Output buffer full, active low |
| irq_o | output | 1 | Interrupt request |
| aux_i | input | 2 | Independent lines read back in status bits 7:6 |
| aux_o | output | 2 | Independent lines written from control bits 7:6 |

## Verification
The bench targets the cycles where two events collide. A strobe and a host read can land together; a design that lets the read win loses the new byte and shows ibf_o low. A data write and an acknowledge can land together; getting that wrong releases obf_no while fresh data sits unsent. A strobe held low across a read is checked because a level-sensitive design would set ibf_o again. Late enabling of the interrupt is checked, where a design that only samples the enable at completion never raises irq_o. An acknowledge with no pending byte is checked, where a careless design raises a spurious request.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // bit offsets inside one group's control-port slice
  localparam int unsigned OFS_IRQ  = 0;
  localparam int unsigned OFS_IE   = 1;
  localparam int unsigned OFS_FULL = 2;
  localparam int unsigned SLICE_W  = 3;

  function automatic int unsigned slice_base(input bit grp_a);
    return grp_a ? SLICE_W : 0;
  endfunction

  typedef struct packed {
    logic full;
    logic ie;
    logic irq;
  } hs_slice_t;
endpackage

// File: rtl/hs_edge_det.sv
module hs_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_ni,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl_ni;
  end

  assign fall_o = lvl_q & ~lvl_ni;
endmodule

// File: rtl/hs_core.sv
module hs_core #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_in_i,
  input  logic          fall_i,
  input  logic          data_rd_i,
  input  logic          data_wr_i,
  input  logic          ie_wr_i,
  input  logic          ie_val_i,
  input  logic [DW-1:0] pad_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] in_q_o,
  output logic [DW-1:0] out_q_o,
  output logic          ibf_o,
  output logic          obf_no,
  output logic          ie_o,
  output logic          irq_o
);
  logic [DW-1:0] in_q, out_q;
  logic          ibf_q, obf_nq, ie_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      out_q  <= '0;
      ibf_q  <= 1'b0;
      obf_nq <= 1'b1;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ie_wr_i) ie_q <= ie_val_i;
      if (dir_in_i) begin
        // a new strobe outranks a host read in the same cycle
        if (fall_i) begin
          in_q   <= pad_i;
          ibf_q  <= 1'b1;
          pend_q <= 1'b1;
        end else if (data_rd_i) begin
          ibf_q  <= 1'b0;
          pend_q <= 1'b0;
        end else if (data_wr_i) begin
          pend_q <= 1'b0;
        end
      end else begin
        // a host write outranks an acknowledge in the same cycle
        if (data_wr_i) begin
          out_q  <= wdata_i;
          obf_nq <= 1'b0;
          pend_q <= 1'b0;
        end else if (fall_i && !obf_nq) begin
          obf_nq <= 1'b1;
          pend_q <= 1'b1;
        end else if (data_rd_i) begin
          pend_q <= 1'b0;
        end
      end
    end
  end

  assign in_q_o  = in_q;
  assign out_q_o = out_q;
  assign ibf_o   = ibf_q;
  assign obf_no  = obf_nq;
  assign ie_o    = ie_q;
  assign irq_o   = pend_q & ie_q;

  p_ibf_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_in_i && data_rd_i && !fall_i |=> !ibf_o);

  p_latch_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(in_q_o));

  p_obf_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_in_i && data_wr_i |=> !obf_no);

  p_obf_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_in_i && !data_wr_i && fall_i && !obf_no |=> obf_no);

  p_irq_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i || data_wr_i) && !fall_i |=> !irq_o);
endmodule

// File: rtl/hs_strobed_port.sv
module hs_strobed_port #(
  parameter int unsigned DW    = 8,
  parameter bit          GRP_A = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_dir_in_i,
  input  logic          host_addr_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic [DW-1:0] pad_data_i,
  output logic [DW-1:0] pad_data_o,
  output logic          pad_data_oe_o,
  input  logic          stb_ack_ni,
  output logic          ibf_o,
  output logic          obf_no,
  output logic          irq_o,
  input  logic [1:0]    aux_i,
  output logic [1:0]    aux_o
);
  import hs_pkg::*;

  localparam int unsigned BASE = slice_base(GRP_A);

  logic          fall, data_rd, data_wr, ctrl_wr, ie;
  logic [DW-1:0] in_q, out_q, stat;
  logic [1:0]    aux_q;
  hs_slice_t     slice;

  assign data_rd = host_rd_i & ~host_addr_i;
  assign data_wr = host_wr_i & ~host_addr_i;
  assign ctrl_wr = host_wr_i &  host_addr_i;

  hs_edge_det i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_ni (stb_ack_ni),
    .fall_o (fall)
  );

  hs_core #(.DW(DW)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dir_in_i  (cfg_dir_in_i),
    .fall_i    (fall),
    .data_rd_i (data_rd),
    .data_wr_i (data_wr),
    .ie_wr_i   (ctrl_wr),
    .ie_val_i  (host_wdata_i[BASE+OFS_IE]),
    .pad_i     (pad_data_i),
    .wdata_i   (host_wdata_i),
    .in_q_o    (in_q),
    .out_q_o   (out_q),
    .ibf_o     (ibf_o),
    .obf_no    (obf_no),
    .ie_o      (ie),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      aux_q <= '0;
    else if (ctrl_wr) aux_q <= host_wdata_i[DW-1:DW-2];
  end

  assign slice.irq  = irq_o;
  assign slice.ie   = ie;
  assign slice.full = cfg_dir_in_i ? ibf_o : ~obf_no;

  always_comb begin
    stat                        = '0;
    stat[BASE +: SLICE_W]       = slice;
    stat[DW-1:DW-2]             = aux_i;
  end

  assign host_rdata_o  = host_addr_i ? stat : (cfg_dir_in_i ? in_q : out_q);
  assign pad_data_o    = out_q;
  assign pad_data_oe_o = ~cfg_dir_in_i;
  assign aux_o         = aux_q;

  p_ie_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ie == $past(host_wdata_i[BASE+OFS_IE]));

  p_aux_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(aux_o));
endmodule

// File: tb/test_hs_strobed_port.sv
`timescale 1ns/1ps
module test_hs_strobed_port;
  localparam int unsigned DW = 8;
  localparam int unsigned WATCHDOG = 5000;
  // group A: irq bit3, ie bit4, full bit5, aux_i bits 7:6
  localparam logic [7:0] B_IRQ = 8'h08, B_IE = 8'h10, B_FULL = 8'h20;
  localparam logic [7:0] PAT [6] = '{8'h5A, 8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81};

  logic          clk = 1'b0, rst_n = 1'b0, dir_in = 1'b1;
  logic          addr = 1'b0, wr = 1'b0, rd = 1'b0, stb_n = 1'b1;
  logic [DW-1:0] wdata = '0, pad_in = '0;
  logic [DW-1:0] rdata, pad_out;
  logic          oe, ibf, obf_n, irq;
  logic [1:0]    aux_in = 2'b10, aux_out;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  hs_strobed_port #(.DW(DW), .GRP_A(1'b1)) i_hs_strobed_port (
    .clk_i(clk), .rst_ni(rst_n), .cfg_dir_in_i(dir_in),
    .host_addr_i(addr), .host_wr_i(wr), .host_rd_i(rd),
    .host_wdata_i(wdata), .host_rdata_o(rdata),
    .pad_data_i(pad_in), .pad_data_o(pad_out), .pad_data_oe_o(oe),
    .stb_ack_ni(stb_n), .ibf_o(ibf), .obf_no(obf_n), .irq_o(irq),
    .aux_i(aux_in), .aux_o(aux_out)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic dir);
    rst_n = 1'b0; dir_in = dir; stb_n = 1'b1; wr = 1'b0; rd = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic host_rd(input logic a, input logic [7:0] exp, input string req);
    addr = a; rd = 1'b1;
    #1 check(rdata, exp, req);
    tick();
    rd = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] d);
    pad_in = d; stb_n = 1'b0;
    tick();
    stb_n = 1'b1;
    tick();
  endtask

  initial begin
    do_reset(1'b1);
    // R1 reset state, R8 status layout
    check({5'b0, ibf, obf_n, irq}, 8'b010, "R1 flags");
    check(aux_out, 2'b00, "R1 aux_o");
    host_rd(1'b1, 8'h80, "R1 R8 status after reset");
    host_rd(1'b0, 8'h00, "R1 input register");
    check(oe, 1'b0, "R10 oe in input mode");

    host_wr(1'b1, 8'hC0 | B_IE);
    check(aux_out, 2'b11, "R9 aux_o");
    host_rd(1'b1, 8'h80 | B_IE, "R7 R8 ie in status");

    // vector walk, input mode
    foreach (PAT[i]) begin
      pad_in = PAT[i]; stb_n = 1'b0;
      tick();
      check(ibf, 1'b1, "R2 ibf set");
      check(irq, 1'b1, "R6 irq on strobe");
      pad_in = ~PAT[i]; stb_n = 1'b1;
      tick();
      host_rd(1'b1, 8'h80 | B_IE | B_FULL | B_IRQ, "R8 status full");
      host_rd(1'b0, PAT[i], "R2 latched data held");
      check(ibf, 1'b0, "R3 ibf cleared by read");
      check(irq, 1'b0, "R6 irq cleared by read");
    end

    // R10 write in input mode ignored
    strobe(8'h77);
    host_wr(1'b0, 8'h11);
    check(ibf, 1'b1, "R10 ibf kept");
    host_rd(1'b0, 8'h77, "R10 register kept");

    // R11 held strobe counts once
    pad_in = 8'h42; stb_n = 1'b0;
    tick();
    check(ibf, 1'b1, "R11 ibf set");
    host_rd(1'b0, 8'h42, "R11 data");
    check(ibf, 1'b0, "R11 ibf cleared");
    pad_in = 8'h24;
    tick();
    check(ibf, 1'b0, "R11 no re-trigger while low");
    stb_n = 1'b1;
    tick();

    // R3 strobe beats read in same cycle
    strobe(8'h10);
    addr = 1'b0; rd = 1'b1; pad_in = 8'h20; stb_n = 1'b0;
    tick();
    rd = 1'b0; stb_n = 1'b1;
    check(ibf, 1'b1, "R3 strobe wins over read");
    tick();
    host_rd(1'b0, 8'h20, "R3 new byte loaded");

    // R7 late enable
    host_wr(1'b1, 8'hC0);
    strobe(8'h99);
    check(irq, 1'b0, "R7 no irq when disabled");
    host_rd(1'b1, 8'h80 | B_FULL, "R8 full without ie");
    host_wr(1'b1, 8'hC0 | B_IE);
    check(irq, 1'b1, "R7 irq after late enable");
    host_wr(1'b1, 8'hC0);
    check(irq, 1'b0, "R7 irq drops on disable");
    host_rd(1'b0, 8'h99, "R3 read");

    // output mode
    do_reset(1'b0);
    check({oe, obf_n}, 2'b11, "R1 R4 output mode reset");
    host_wr(1'b1, B_IE);
    host_wr(1'b0, 8'hC3);
    check(obf_n, 1'b0, "R4 obf low");
    check(pad_out, 8'hC3, "R4 pad data");
    host_rd(1'b1, 8'h80 | B_IE | B_FULL, "R8 output full");
    stb_n = 1'b0; tick();
    check(obf_n, 1'b1, "R5 ack releases obf");
    check(irq, 1'b1, "R6 irq on ack");
    stb_n = 1'b1; tick();
    host_wr(1'b0, 8'h3E);
    check(irq, 1'b0, "R6 write clears irq");
    check(obf_n, 1'b0, "R4 obf low again");
    addr = 1'b0; wdata = 8'h55; wr = 1'b1; stb_n = 1'b0;
    tick();
    wr = 1'b0; stb_n = 1'b1;
    check(obf_n, 1'b0, "R5 write beats ack");
    check(pad_out, 8'h55, "R5 new byte driven");
    check(irq, 1'b0, "R5 no completion on collision");
    tick();
    strobe(8'h00);
    check(obf_n, 1'b1, "R5 second ack");
    check(irq, 1'b1, "R6 irq");
    host_rd(1'b0, 8'h55, "R6 read output register");
    check(irq, 1'b0, "R6 read clears irq");
    strobe(8'h00);
    check(irq, 1'b0, "R5 ack with empty buffer");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule